// File: doc/BRIEF.md
# Cascaded Programmable Clock Generator

This block derives three programmable clock-enable streams from a system tick (`sys_tick`) and a double-rate tick (`dbl_tick`). Everything runs in one clock domain. Each derived clock is a train of one-cycle enable pulses. The first stage divides the system tick. The second stage divides the first stage's pulses. The third stage divides one of four sources chosen by a 2-bit select.

Each division ratio is its field value plus one. The two cascaded stages therefore reach ratios 1 to 16, and the third stage reaches 1 to 256.

Settings change only at period boundaries, so no stage ever emits a shortened period:
- A new ratio or source is captured only when the stage emits its pulse.
- The third stage's counter restarts at the moment it switches source.

A sticky interrupt flag is raised by third-stage pulses when the interrupt is enabled. It stays set until it is acknowledged.

Top module: `cascade_clkgen`

## Requirements
- R1: While reset is held and after its release, with no tick input high, `stage1_tick`, `stage2_tick`, `stage3_tick` and `stage3_irq` are all low.
- R2: `stage1_tick` pulses on every (`stage1_ratio`+1)-th `sys_tick` pulse, in the same cycle as that `sys_tick`. With a field of 0, `stage1_tick` equals `sys_tick`.
- R3: `stage2_tick` pulses on every (`stage2_ratio`+1)-th `stage1_tick` pulse, in the same cycle as that pulse.
- R4: `stage3_tick` pulses on every (`stage3_ratio`+1)-th pulse of its selected source, with ratios up to 256 (a field of 255). Source VC2 with a field of 255 is the slowest idle setting.
- R5: `stage3_src` selects the third-stage source as follows: 0 selects `sys_tick`, 1 selects `dbl_tick`, 2 selects `stage2_tick`, and 3 selects `stage1_tick`.
- R6: A change of `stage1_ratio` or `stage2_ratio` is captured only in the cycle where that stage emits a pulse. The period in progress completes at the old ratio.
- R7: A change of `stage3_ratio` is captured only in the cycle where `stage3_tick` pulses. The period in progress completes at the old ratio.
- R8: A change of `stage3_src` is applied only in the cycle where `stage3_tick` pulses. From the next cycle, the third stage counts the new source from zero.
- R9: `stage3_irq` is set in the cycle after a `stage3_tick` pulse that coincides with `irq_enable` high. It stays set until a cycle with `irq_ack` high, and it is low in the cycle after that. If a set and an acknowledge coincide, the set wins.
- R10: No stage pulses in a cycle where its selected input tick is low.
- R11: After reset, the first input pulse of each stage produces an output pulse and captures that stage's current ratio (and, for the third stage, its source).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | System clock enable pulse |
| dbl_tick | input | 1 | Double-rate clock enable pulse |
| stage1_ratio | input | 4 | First-stage divide field (ratio = field+1) |
| stage2_ratio | input | 4 | Second-stage divide field (ratio = field+1) |
| stage3_ratio | input | 8 | Third-stage divide field (ratio = field+1) |
| stage3_src | input | 2 | Third-stage source select |
| irq_enable | input | 1 | Allows third-stage pulses to raise the interrupt flag |
| irq_ack | input | 1 | Clears the interrupt flag |
| stage1_tick | output | 1 | First-stage enable pulse |
| stage2_tick | output | 1 | Second-stage enable pulse |
| stage3_tick | output | 1 | Third-stage enable pulse |
| stage3_irq | output | 1 | Sticky third-stage interrupt flag |

## Verification
The hardest situation to reach is a setting change that lands in the middle of a period. This matters most for a source switch: the old and new sources pulse at unrelated rates, and the third stage must neither cut the old period short nor carry its count into the new source.

The stimulus changes fields and the select at arbitrary cycles while the sources keep running. The system tick has irregular gaps, so the changes fall at varied points inside the periods. A cycle-level reference model in the bench, driven by the same inputs, supplies the expected pulse for every cycle.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;
  typedef enum logic [1:0] {
    SRC_SYS = 2'd0,
    SRC_DBL = 2'd1,
    SRC_VC2 = 2'd2,
    SRC_VC1 = 2'd3
  } stage3_src_e;
endpackage

// File: rtl/ckgen_divider.sv
module ckgen_divider #(
  parameter int unsigned FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_in,
  input  logic [FIELD_W-1:0] ratio_fld,
  output logic               tick_out
);
  logic [FIELD_W-1:0] cnt_q;
  logic [FIELD_W-1:0] active_q;

  // Terminal count of the running period gates the input tick.
  assign tick_out = tick_in && (cnt_q == active_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= '0;
    end else if (tick_in) begin
      if (cnt_q == active_q) begin
        cnt_q    <= '0;
        active_q <= ratio_fld;   // new ratio only at a period boundary
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ckgen_srcsel.sv
module ckgen_srcsel
  import ckgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_req,
  input  logic       period_end,
  input  logic       sys_tick,
  input  logic       dbl_tick,
  input  logic       vc1_tick,
  input  logic       vc2_tick,
  output logic       src_tick
);
  stage3_src_e sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_q <= SRC_SYS;
    else if (period_end) sel_q <= stage3_src_e'(sel_req);
  end

  always_comb begin
    unique case (sel_q)
      SRC_SYS: src_tick = sys_tick;
      SRC_DBL: src_tick = dbl_tick;
      SRC_VC2: src_tick = vc2_tick;
      SRC_VC1: src_tick = vc1_tick;
      default: src_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/cascade_clkgen.sv
module cascade_clkgen #(
  parameter int unsigned NARROW_W = 4,
  parameter int unsigned WIDE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sys_tick,
  input  logic                dbl_tick,
  input  logic [NARROW_W-1:0] stage1_ratio,
  input  logic [NARROW_W-1:0] stage2_ratio,
  input  logic [WIDE_W-1:0]   stage3_ratio,
  input  logic [1:0]          stage3_src,
  input  logic                irq_enable,
  input  logic                irq_ack,
  output logic                stage1_tick,
  output logic                stage2_tick,
  output logic                stage3_tick,
  output logic                stage3_irq
);
  logic src3_tick;
  logic irq_q;

  ckgen_divider #(.FIELD_W(NARROW_W)) u_stage1 (
    .clk(clk), .rst_n(rst_n), .tick_in(sys_tick),
    .ratio_fld(stage1_ratio), .tick_out(stage1_tick));

  ckgen_divider #(.FIELD_W(NARROW_W)) u_stage2 (
    .clk(clk), .rst_n(rst_n), .tick_in(stage1_tick),
    .ratio_fld(stage2_ratio), .tick_out(stage2_tick));

  ckgen_srcsel u_sel (
    .clk(clk), .rst_n(rst_n), .sel_req(stage3_src),
    .period_end(stage3_tick), .sys_tick(sys_tick), .dbl_tick(dbl_tick),
    .vc1_tick(stage1_tick), .vc2_tick(stage2_tick), .src_tick(src3_tick));

  ckgen_divider #(.FIELD_W(WIDE_W)) u_stage3 (
    .clk(clk), .rst_n(rst_n), .tick_in(src3_tick),
    .ratio_fld(stage3_ratio), .tick_out(stage3_tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         irq_q <= 1'b0;
    else if (stage3_tick && irq_enable) irq_q <= 1'b1;
    else if (irq_ack)                   irq_q <= 1'b0;
  end

  assign stage3_irq = irq_q;
endmodule

// File: rtl/cascade_clkgen_checker.sv
module cascade_clkgen_checker (
  input logic clk,
  input logic rst_n,
  input logic sys_tick,
  input logic dbl_tick,
  input logic irq_enable,
  input logic irq_ack,
  input logic stage1_tick,
  input logic stage2_tick,
  input logic stage3_tick,
  input logic stage3_irq
);
  AST_VC1_NEEDS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    stage1_tick |-> sys_tick); // R10
  AST_VC2_NEEDS_VC1: assert property (@(posedge clk) disable iff (!rst_n)
    stage2_tick |-> stage1_tick); // R3
  AST_VC3_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    stage3_tick |-> (sys_tick || dbl_tick)); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (stage3_tick && irq_enable) |=> stage3_irq); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stage3_irq && !irq_ack) |=> stage3_irq); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stage3_irq && irq_ack && !(stage3_tick && irq_enable)) |=> !stage3_irq); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage3_irq) |-> $past(stage3_tick && irq_enable)); // R9
endmodule

bind cascade_clkgen cascade_clkgen_checker u_checker (
  .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .dbl_tick(dbl_tick),
  .irq_enable(irq_enable), .irq_ack(irq_ack), .stage1_tick(stage1_tick),
  .stage2_tick(stage2_tick), .stage3_tick(stage3_tick), .stage3_irq(stage3_irq));

// File: tb/cascade_clkgen_bench.sv
module cascade_clkgen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_tick = 1'b0, dbl_tick = 1'b0;
  logic [3:0] stage1_ratio = '0, stage2_ratio = '0;
  logic [7:0] stage3_ratio = '0;
  logic [1:0] stage3_src = '0;
  logic irq_enable = 1'b0, irq_ack = 1'b0;
  logic stage1_tick, stage2_tick, stage3_tick, stage3_irq;

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R1";
  int ack_every = 0;

  typedef struct {
    logic v1, v2, v3, irq;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // reference model state
  int m1c = 0, m1a = 0, m2c = 0, m2a = 0, m3c = 0, m3a = 0, msel = 0;
  bit mirq = 0;

  always #5 clk = ~clk;

  cascade_clkgen u_cascade_clkgen (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .dbl_tick(dbl_tick),
    .stage1_ratio(stage1_ratio), .stage2_ratio(stage2_ratio),
    .stage3_ratio(stage3_ratio), .stage3_src(stage3_src),
    .irq_enable(irq_enable), .irq_ack(irq_ack),
    .stage1_tick(stage1_tick), .stage2_tick(stage2_tick),
    .stage3_tick(stage3_tick), .stage3_irq(stage3_irq));

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic drive(input logic s, input logic d, input logic ack);
    exp_t e;
    logic v1, v2, v3, src;
    @(negedge clk);
    sys_tick = s; dbl_tick = d; irq_ack = ack;
    v1 = s && (m1c == m1a);
    v2 = v1 && (m2c == m2a);
    case (msel)
      0: src = s;
      1: src = d;
      2: src = v2;
      default: src = v1;
    endcase
    v3 = src && (m3c == m3a);
    e.v1 = v1; e.v2 = v2; e.v3 = v3; e.irq = mirq; e.tag = phase;
    sb_q.push_back(e);
    if (s) begin
      if (v1) begin m1c = 0; m1a = int'(stage1_ratio); end else m1c++;
    end
    if (v1) begin
      if (v2) begin m2c = 0; m2a = int'(stage2_ratio); end else m2c++;
    end
    if (src) begin
      if (v3) begin
        m3c = 0; m3a = int'(stage3_ratio); msel = int'(stage3_src);
      end else m3c++;
    end
    if (v3 && irq_enable) mirq = 1;
    else if (ack) mirq = 0;
  endtask

  // monitor: pops expected items and compares away from the clock edge
  always @(negedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk({e.tag, " R2 vc1"}, stage1_tick, e.v1);
      chk({e.tag, " R3 vc2"}, stage2_tick, e.v2);
      chk({e.tag, " R4 vc3"}, stage3_tick, e.v3);
      chk({e.tag, " R9 irq"}, stage3_irq, e.irq);
    end
  end

  int k = 0;
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      logic s, d, a;
      s = (k % 4 == 0) && (k % 28 != 24) && (k % 37 != 0);
      d = (k % 2 == 0);
      a = (ack_every != 0) && (k % ack_every == 3);
      drive(s, d, a);
      k++;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 vc1 in reset", stage1_tick, 1'b0);
    chk("R1 vc2 in reset", stage2_tick, 1'b0);
    chk("R1 vc3 in reset", stage3_tick, 1'b0);
    chk("R1 irq in reset", stage3_irq, 1'b0);
    stage1_ratio = 4'd2; stage2_ratio = 4'd1; stage3_ratio = 8'd3;
    stage3_src = 2'd0; irq_enable = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1 irq after reset", stage3_irq, 1'b0);
    chk("R1 vc1 after reset", stage1_tick, 1'b0);
    phase = "R11 first";
    run(140);
    phase = "R6 mid-period ratio change";
    run(9);
    stage1_ratio = 4'd0; stage2_ratio = 4'd3;
    run(120);
    phase = "R7 vc3 ratio change";
    run(5);
    stage3_ratio = 8'd1;
    run(100);
    phase = "R5 R8 src dbl";
    stage3_src = 2'd1;
    run(90);
    phase = "R5 R8 src vc1";
    stage3_src = 2'd3; stage1_ratio = 4'd1;
    run(90);
    phase = "R5 R8 src vc2";
    stage3_src = 2'd2;
    run(150);
    phase = "R9 ack";
    irq_enable = 1'b1; stage3_ratio = 8'd0; stage3_src = 2'd0; ack_every = 5;
    run(120);
    irq_enable = 1'b0;
    run(60);
    ack_every = 0;
    phase = "R4 R10 idle 256";
    irq_enable = 1'b1;
    stage1_ratio = 4'd0; stage2_ratio = 4'd1; stage3_ratio = 8'd255; stage3_src = 2'd2;
    run(4800);
    drive(1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule